// File: doc/BRIEF.md
# Delta-Sigma Converter Conversion and Readout Sequencer

This block is the control side of a converter that sleeps on its own between conversions. It runs a conversion of a fixed number of oscillator cycles, then takes a 20-bit result from a parallel input. That input stands in for the modulator and filter, which are outside this block. After each conversion the block sleeps, holding the word. Once the active-low select is low, it shifts the word out on the serial data output, MSB first. The serial clock is sampled by the oscillator clock, and a new bit is presented after each falling edge of the serial clock.

While the select is low and no word is being sent, the data output shows a status bit: 1 while a conversion is running and 0 once a result is ready. The block gives a separate output enable so that a pad can build the three-state pin; the enable is low whenever the select is high. Raising the select while the word is being sent stops the transfer and starts a new conversion. Sending the last bit also starts a new conversion.

States: `ST_CONVERT` (counting the conversion), `ST_SLEEP` (result held), `ST_DATA_OUT` (shifting). Transitions: reset → `ST_CONVERT`; `ST_CONVERT` → `ST_SLEEP` when the count ends; `ST_SLEEP` → `ST_DATA_OUT` when the select is low; `ST_DATA_OUT` → `ST_CONVERT` on the select rising (abort) or on the final falling serial-clock edge (done).

Top module: `adc_seq_ctrl`

## Requirements
- R1: A conversion lasts exactly CONV_CYCLES clock cycles (default 20480). When a conversion is started by an abort or by the end of a readout, the busy status is seen on exactly 20480 consecutive cycles with the select low.
- R2: At the end of a conversion, `result_in` is captured and the block enters sleep. It stays in sleep for as long as `cs_n` is high. Changes of `result_in` and toggles of `sck` during sleep do not alter the captured word.
- R3: `sdo_oe` is 0 whenever `cs_n` is high and 1 whenever `cs_n` is low.
- R4: With `cs_n` low, `sdo_data` is 1 during a conversion (busy) and 0 in sleep (ready).
- R5: From sleep with `cs_n` low, the data-output state is entered on the next cycle, with bit 19 (the MSB) on `sdo_data`. A falling `sck` edge is `sck` sampled high and then low on consecutive clock edges. Each falling edge presents the next lower bit. A rising edge leaves `sdo_data` unchanged.
- R6: The 20th falling `sck` edge in the data-output state starts a new conversion.
- R7: `cs_n` high during the data-output state aborts the transfer and starts a new conversion. If the select rises in the same cycle as the final falling edge, only one conversion is started.
- R8: The 20-bit word is sent unchanged, including zero scale 0x00000 and full scale 0xFFFFF.
- R9: Reset (`rst_n` low) puts the block in the converting state with its cycle count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select, synchronous to clk |
| sck | input | 1 | Serial shift clock, sampled by clk |
| result_in | input | WORD_W | Parallel conversion result (stub) |
| sdo_data | output | 1 | Serial data or conversion status |
| sdo_oe | output | 1 | Output enable for the three-state data pin |

## Verification
Two things can happen in the same clock: the select rises (abort) and the final falling `sck` edge arrives (readout complete). Both would start a conversion. The bench provokes this by driving `sck` low and `cs_n` high at the same instant after the 19th bit has been shifted. It then judges the result by the enable dropping at once and by exactly 20480 busy samples when the select is next low, which shows that only one conversion was started. A second overlap, the end of a conversion while the select is already low, is judged by a single ready sample followed directly by the MSB.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_CONVERT  = 2'd0,
        ST_SLEEP    = 2'd1,
        ST_DATA_OUT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/adc_seq_edge.sv
module adc_seq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic fall
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign fall = sig_q & ~sig;
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int CONV_CYCLES = 20480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(CONV_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!run)       cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] din,
    input  logic              shift_en,
    output logic              msb,
    output logic              last
);
    localparam int BCW = $clog2(WORD_W);
    localparam logic [BCW-1:0] FINAL = BCW'(WORD_W - 1);

    logic [WORD_W-1:0] sreg_q;
    logic [BCW-1:0]    bcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            bcnt_q <= '0;
        end else if (load) begin
            sreg_q <= din;
            bcnt_q <= '0;
        end else if (shift_en) begin
            sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
            bcnt_q <= (bcnt_q == FINAL) ? '0 : bcnt_q + 1'b1;
        end
    end

    assign msb  = sreg_q[WORD_W-1];
    assign last = shift_en && (bcnt_q == FINAL);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CONV_CYCLES = 20480,
    parameter int WORD_W      = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic [WORD_W-1:0] result_in,
    output logic              sdo_data,
    output logic              sdo_oe
);
    seq_state_e state_q, state_d;
    logic       sck_fall, conv_done, shift_en, word_msb, word_last;

    adc_seq_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (sck),
        .fall  (sck_fall)
    );

    adc_seq_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_CONVERT),
        .done  (conv_done)
    );

    assign shift_en = sck_fall && !cs_n && (state_q == ST_DATA_OUT);

    adc_seq_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (conv_done),
        .din      (result_in),
        .shift_en (shift_en),
        .msb      (word_msb),
        .last     (word_last)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CONVERT:  if (conv_done) state_d = ST_SLEEP;
            ST_SLEEP:    if (!cs_n)     state_d = ST_DATA_OUT;
            ST_DATA_OUT: if (cs_n || word_last) state_d = ST_CONVERT;
            default:     state_d = ST_CONVERT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CONVERT;
        else        state_q <= state_d;
    end

    always_comb begin
        sdo_oe = ~cs_n;
        unique case (state_q)
            ST_CONVERT:  sdo_data = 1'b1;
            ST_SLEEP:    sdo_data = 1'b0;
            ST_DATA_OUT: sdo_data = word_msb;
            default:     sdo_data = 1'b1;
        endcase
    end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int CONV_CYCLES = 20480
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sck,
    input logic       sdo_data,
    input logic       sdo_oe,
    input seq_state_e state
);
    logic sck_prev;
    int   conv_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            conv_len <= 0;
        end else begin
            sck_prev <= sck;
            conv_len <= (state == ST_CONVERT) ? conv_len + 1 : 0;
        end
    end

    p_conv_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && $past(state) == ST_CONVERT) |-> conv_len == CONV_CYCLES);

    p_sleep_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && cs_n) |=> state == ST_SLEEP);

    p_oe_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sdo_oe);

    p_ready_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !cs_n) |-> !sdo_data);

    p_enter_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !cs_n) |=> state == ST_DATA_OUT);

    p_hold_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA_OUT && !cs_n && !(sck_prev && !sck)) |=> $stable(sdo_data));

    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA_OUT && cs_n) |=> state == ST_CONVERT);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sck      (sck),
    .sdo_data (sdo_data),
    .sdo_oe   (sdo_oe),
    .state    (state_q)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
    localparam int CONV = 20480;
    localparam int W    = 20;

    logic         clk = 1'b0;
    logic         rst_n, cs_n, sck;
    logic [W-1:0] result_in;
    logic         sdo_data, sdo_oe;
    int           n_checks = 0;
    int           n_fail   = 0;

    always #2.5 clk = ~clk;

    adc_seq_ctrl #(.CONV_CYCLES(CONV), .WORD_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
        .result_in(result_in), .sdo_data(sdo_data), .sdo_oe(sdo_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reads the top nbits of exp; optionally raises cs_n together with the final sck fall
    task automatic read_word(input logic [W-1:0] exp, input int nbits, input bit cs_on_last,
                             input string req);
        for (int i = W - 1; i >= W - nbits; i--) begin
            @(negedge clk); #1;
            chk(req, sdo_data, exp[i]);
            sck = 1'b1;
            @(negedge clk); #1;
            chk("R5 rising sck holds bit", sdo_data, exp[i]);
            sck = 1'b0;
            if (cs_on_last && i == W - nbits) begin
                cs_n = 1'b1;
                #1 chk("R3/R7 enable drops on coincident abort", sdo_oe, 1'b0);
            end
        end
    endtask

    // Counts busy samples of a conversion started at the preceding clock edge
    task automatic count_conv(input string req);
        int busy = 0;
        for (int g = 0; g < CONV + 100; g++) begin
            @(negedge clk);
            cs_n = 1'b0;
            #1;
            if (sdo_oe && sdo_data) busy++;
            else break;
        end
        chk(req, busy, CONV);
        chk("R4 ready status after conversion", {sdo_oe, sdo_data}, 2'b10);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; result_in = 20'hA5C3E;
        repeat (3) @(negedge clk);
        #1 chk("R9/R4 busy during reset", {sdo_oe, sdo_data}, 2'b11);
        @(negedge clk);
        rst_n = 1'b1; cs_n = 1'b1;
        #1 chk("R3 enable off with select high", sdo_oe, 1'b0);
    endtask

    task automatic t_sleep_hold;
        repeat (CONV + 20) @(negedge clk);
        result_in = 20'h00000;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); sck = 1'b1;
            @(negedge clk); sck = 1'b0;
        end
        #1 chk("R3 enable off in sleep", sdo_oe, 1'b0);
        @(negedge clk);
        cs_n = 1'b0;
        #1 chk("R4 ready status in sleep", {sdo_oe, sdo_data}, 2'b10);
        read_word(20'hA5C3E, W, 1'b0, "R2/R5 captured word MSB first");
    endtask

    task automatic t_zero_scale;
        count_conv("R1/R6 length after full readout");
        read_word(20'h00000, W, 1'b0, "R8 zero scale word");
    endtask

    task automatic t_abort;
        result_in = 20'hFFFFF;
        count_conv("R1/R6 length after second readout");
        read_word(20'hFFFFF, 7, 1'b0, "R8 full scale bits");
        result_in = 20'h12345;
        @(negedge clk);
        cs_n = 1'b1;
        #1 chk("R3 enable off at abort", sdo_oe, 1'b0);
        count_conv("R7/R1 new conversion after abort");
    endtask

    task automatic t_coincide;
        read_word(20'h12345, W, 1'b1, "R5/R8 word before coincident abort");
        count_conv("R7 single restart on coincident abort and last edge");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_sleep_hold();
        t_zero_scale();
        t_abort();
        t_coincide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule